// File: doc/BRIEF.md
# Video Test Pattern Pixel Generator

This block turns raster coordinates into test-pattern colour. Once per pixel clock it looks at the data-enable strobe and at the column and row of the current pixel inside the active region, which an upstream timing generator supplies. It also takes a 4-bit pattern code and a small set of configuration bits. One clock later it presents a 24-bit RGB word, together with a delayed copy of the strobe.

The patterns come from one code table:
- full-screen solid colours;
- a user-programmed colour;
- horizontal and vertical brightness ramps, each in four tints;
- a checkerboard;
- a four-colour striped checkerboard, called the comb pattern here.

A separate override bit replaces all of these with eight vertical colour bars. Each ramp is stretched over the programmed active width or height, so it always runs from darkest to brightest whatever the frame size. Two stages act on the result last: a global bitwise inversion, and a reduced 18-bit colour mode.

The ramps avoid a per-pixel divider. For each axis, a serial divider works out the step size whenever the frame size or colour depth changes. A per-line accumulator and a per-frame accumulator then walk that step pixel by pixel and line by line.

Top module: `tpg_pixel_gen`

## Requirements
- R1: While reset is high and on the first output after it, `de_o` is 0 and `rgb_o` is 0.
- R2: `de_o` equals `de_i` of the previous clock. `rgb_o` is the colour for the inputs of the previous clock, and is all zeros whenever that `de_i` was 0. `rgb_o` packs red in [23:16], green in [15:8] and blue in [7:0].
- R3: The solid colour codes are:
  - 0001: white FFFFFF;
  - 0010: black 000000;
  - 0011: red FF0000;
  - 0100: green 00FF00;
  - 0101: blue 0000FF;
  - 1110: the custom colour {cust_r_i, cust_g_i, cust_b_i}.
- R4: Codes 0110, 0111, 1000 and 1001 are horizontal ramps in white, red, green and blue. The brightness level is floor(col × L / act_w), where L is 256 (level used as the byte) or 64 in 18-bit mode. Columns must arrive in order from 0 within each line. After a change of `act_w`, `act_h` or `mode18_i`, 16 clocks without active pixels are needed before the ramp values are valid.
- R5: Codes 1010, 1011, 1100 and 1101 are vertical ramps in the same four tints. The level is floor(row × L / act_h), and rows must arrive in order from 0.
- R6: When `mode18_i` is 1, bits 1:0 of every channel are 0 for every pixel, including inverted ones. A ramp level (0..63) is then placed in bits 7:2.
- R7: When `inv_i` is 1, every bit of the pattern colour is inverted before the 18-bit masking.
- R8: Code 0000 is a checkerboard. A square is white when its square-column plus square-row is even, and black otherwise. A square is 1×1 pixel, or 8×8 pixels when `chk_scale_i` is 1.
- R9: When `chk_custom_i` is 1, the lit checkerboard squares take the custom colour instead of white.
- R10: Code 1111 is the comb pattern. It uses the same square grid and scaling as R8. Dark squares are black. Lit squares are coloured by square-row mod 4: yellow FFFF00, cyan 00FFFF, blue 0000FF, red FF0000.
- R11: When `bars_i` is 1, the pattern code is ignored. The output is band floor(col × 8 / act_w) of the sequence white, yellow, cyan, green, magenta, red, blue, black.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| de_i | input | 1 | Active-pixel strobe |
| col_i | input | PW | Column inside the active region |
| row_i | input | PW | Row inside the active region |
| act_w | input | PW | Active width in pixels |
| act_h | input | PW | Active height in lines |
| pat_i | input | 4 | Pattern code |
| inv_i | input | 1 | Invert all colour bits |
| mode18_i | input | 1 | 18-bit colour mode |
| chk_scale_i | input | 1 | 8×8 squares for the checkerboard and comb patterns |
| chk_custom_i | input | 1 | Custom colour on lit checkerboard squares |
| bars_i | input | 1 | Colour-bar override |
| cust_r_i | input | 8 | Custom red |
| cust_g_i | input | 8 | Custom green |
| cust_b_i | input | 8 | Custom blue |
| de_o | output | 1 | Strobe delayed by one clock |
| rgb_o | output | 24 | Registered pixel colour |

## Verification
Inversion and 18-bit truncation act on the same pixel in the same cycle. If the masking were applied before the inversion, the low two bits of every channel would come out set. The bench runs whole frames of every pattern code with both `inv_i` and `mode18_i` raised, and compares each output word with a behavioural model that inverts first and masks last.

The colour-bar override and the pattern code also meet in one cycle. Frames are therefore sent with bars enabled while the code steps through ramp and checkerboard values, and every pixel must match the band colour.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  typedef enum logic [3:0] {
    PAT_CHECK  = 4'd0,
    PAT_WHITE  = 4'd1,
    PAT_BLACK  = 4'd2,
    PAT_RED    = 4'd3,
    PAT_GREEN  = 4'd4,
    PAT_BLUE   = 4'd5,
    PAT_HR_W   = 4'd6,
    PAT_HR_R   = 4'd7,
    PAT_HR_G   = 4'd8,
    PAT_HR_B   = 4'd9,
    PAT_VR_W   = 4'd10,
    PAT_VR_R   = 4'd11,
    PAT_VR_G   = 4'd12,
    PAT_VR_B   = 4'd13,
    PAT_CUSTOM = 4'd14,
    PAT_COMB   = 4'd15
  } pat_e;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

  // one brightness byte spread on a tint: 0 white, 1 red, 2 green, 3 blue
  function automatic rgb_t tint(input logic [7:0] v, input logic [1:0] sel);
    rgb_t c;
    c.r = (sel == 2'd0 || sel == 2'd1) ? v : 8'h00;
    c.g = (sel == 2'd0 || sel == 2'd2) ? v : 8'h00;
    c.b = (sel == 2'd0 || sel == 2'd3) ? v : 8'h00;
    return c;
  endfunction

  // full-scale colour from three on/off bits {r,g,b}
  function automatic rgb_t prim(input logic [2:0] bits);
    rgb_t c;
    c.r = {8{bits[2]}};
    c.g = {8{bits[1]}};
    c.b = {8{bits[0]}};
    return c;
  endfunction

endpackage

// File: rtl/tpg_div.sv
// Serial restoring divider: num / den, restarted whenever an operand changes.
module tpg_div #(
  parameter int DW = 12,
  parameter int NW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic [NW-1:0] quo,
  output logic [DW-1:0] rem
);
  localparam int CW = $clog2(NW + 1);
  localparam int XW = NW + DW + 1;

  logic [NW-1:0] lat_num, shreg, q_acc;
  logic [DW-1:0] lat_den;
  logic [DW:0]   r_acc, r_try;
  logic [CW-1:0] cnt;
  logic          busy, ready;

  always_comb r_try = {r_acc[DW-1:0], shreg[NW-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_num <= '0;
      lat_den <= '0;
      shreg   <= '0;
      q_acc   <= '0;
      r_acc   <= '0;
      cnt     <= '0;
      busy    <= 1'b0;
      ready   <= 1'b0;
    end else if (num != lat_num || den != lat_den) begin
      lat_num <= num;
      lat_den <= den;
      shreg   <= num;
      q_acc   <= '0;
      r_acc   <= '0;
      cnt     <= CW'(NW);
      busy    <= 1'b1;
      ready   <= 1'b0;
    end else if (busy) begin
      if (r_try >= {1'b0, lat_den}) begin
        r_acc <= r_try - {1'b0, lat_den};
        q_acc <= {q_acc[NW-2:0], 1'b1};
      end else begin
        r_acc <= r_try;
        q_acc <= {q_acc[NW-2:0], 1'b0};
      end
      shreg <= {shreg[NW-2:0], 1'b0};
      cnt   <= cnt - 1'b1;
      if (cnt == CW'(1)) begin
        busy  <= 1'b0;
        ready <= 1'b1;
      end
    end
  end

  assign quo = q_acc;
  assign rem = r_acc[DW-1:0];

  // R4 / R5: the step pair must reconstruct the ramp span exactly
  a_r4_div_exact: assert property (@(posedge clk) disable iff (rst)
    (ready && lat_den != '0) |->
      ((XW'(q_acc) * XW'(lat_den) + XW'(r_acc)) == XW'(lat_num)));

  a_r5_div_rem_bound: assert property (@(posedge clk) disable iff (rst)
    (ready && lat_den != '0) |-> (r_acc < {1'b0, lat_den}));

endmodule

// File: rtl/tpg_ramp_acc.sv
// Walks floor(pos * L / den) one position at a time using a precomputed step.
module tpg_ramp_acc #(
  parameter int PW = 12,
  parameter int NW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          start,
  input  logic [NW-1:0] step_q,
  input  logic [PW-1:0] step_r,
  input  logic [PW-1:0] den,
  output logic [7:0]    level
);
  logic [NW:0]   nq, cur_q, nxt_q;
  logic [PW-1:0] nr, cur_r;
  logic [PW:0]   sum_r, nxt_r;
  logic [7:0]    held;
  logic          carry;

  always_comb begin
    cur_q = start ? '0 : nq;
    cur_r = start ? '0 : nr;
    sum_r = {1'b0, cur_r} + {1'b0, step_r};
    carry = sum_r >= {1'b0, den};
    nxt_r = carry ? (sum_r - {1'b0, den}) : sum_r;
    nxt_q = cur_q + {1'b0, step_q} + {{NW{1'b0}}, carry};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nq   <= '0;
      nr   <= '0;
      held <= '0;
    end else if (adv) begin
      held <= cur_q[7:0];
      nq   <= nxt_q;
      nr   <= nxt_r[PW-1:0];
    end
  end

  assign level = adv ? cur_q[7:0] : held;

endmodule

// File: rtl/tpg_pixel_gen.sv
module tpg_pixel_gen #(
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          de_i,
  input  logic [PW-1:0] col_i,
  input  logic [PW-1:0] row_i,
  input  logic [PW-1:0] act_w,
  input  logic [PW-1:0] act_h,
  input  logic [3:0]    pat_i,
  input  logic          inv_i,
  input  logic          mode18_i,
  input  logic          chk_scale_i,
  input  logic          chk_custom_i,
  input  logic          bars_i,
  input  logic [7:0]    cust_r_i,
  input  logic [7:0]    cust_g_i,
  input  logic [7:0]    cust_b_i,
  output logic          de_o,
  output logic [23:0]   rgb_o
);
  import tpg_pkg::*;

  localparam int NW     = 9;
  localparam int NAXIS  = 2;
  localparam logic [NW-1:0] SPAN24 = NW'(256);
  localparam logic [NW-1:0] SPAN18 = NW'(64);

  logic [NW-1:0] span;
  logic [PW-1:0] den_a   [NAXIS];
  logic          adv_a   [NAXIS];
  logic          start_a [NAXIS];
  logic [NW-1:0] sq_a    [NAXIS];
  logic [PW-1:0] sr_a    [NAXIS];
  logic [7:0]    lvl_a   [NAXIS];

  assign span = mode18_i ? SPAN18 : SPAN24;

  // axis 0 walks along a line, axis 1 walks down the frame
  for (genvar g = 0; g < NAXIS; g++) begin : g_axis
    if (g == 0) begin : g_h
      assign den_a[g]   = act_w;
      assign adv_a[g]   = de_i;
      assign start_a[g] = (col_i == '0);
    end else begin : g_v
      assign den_a[g]   = act_h;
      assign adv_a[g]   = de_i && (col_i == '0);
      assign start_a[g] = (row_i == '0);
    end

    tpg_div #(.DW(PW), .NW(NW)) u_div (
      .clk (clk),
      .rst (rst),
      .num (span),
      .den (den_a[g]),
      .quo (sq_a[g]),
      .rem (sr_a[g])
    );

    tpg_ramp_acc #(.PW(PW), .NW(NW)) u_acc (
      .clk    (clk),
      .rst    (rst),
      .adv    (adv_a[g]),
      .start  (start_a[g]),
      .step_q (sq_a[g]),
      .step_r (sr_a[g]),
      .den    (den_a[g]),
      .level  (lvl_a[g])
    );
  end

  logic [7:0] bright_h, bright_v;
  logic [2:0] band;
  logic       dark_sq;
  logic [1:0] comb_idx;
  rgb_t       custom, pix, pix_x;
  logic [23:0] mask;

  always_comb begin
    bright_h = mode18_i ? {lvl_a[0][5:0], 2'b00} : lvl_a[0];
    bright_v = mode18_i ? {lvl_a[1][5:0], 2'b00} : lvl_a[1];
    band     = mode18_i ? lvl_a[0][5:3] : lvl_a[0][7:5];
    dark_sq  = chk_scale_i ? (col_i[3] ^ row_i[3]) : (col_i[0] ^ row_i[0]);
    comb_idx = chk_scale_i ? row_i[4:3] : row_i[1:0];
    custom   = '{r: cust_r_i, g: cust_g_i, b: cust_b_i};
    mask     = mode18_i ? 24'hFCFCFC : 24'hFFFFFF;

    if (bars_i) begin
      pix = prim({~band[1], ~band[2], ~band[0]});
    end else begin
      unique case (pat_e'(pat_i))
        PAT_WHITE:  pix = prim(3'b111);
        PAT_BLACK:  pix = prim(3'b000);
        PAT_RED:    pix = prim(3'b100);
        PAT_GREEN:  pix = prim(3'b010);
        PAT_BLUE:   pix = prim(3'b001);
        PAT_HR_W, PAT_HR_R, PAT_HR_G, PAT_HR_B:
          pix = tint(bright_h, pat_i[1:0] + 2'd2);
        PAT_VR_W, PAT_VR_R, PAT_VR_G, PAT_VR_B:
          pix = tint(bright_v, pat_i[1:0] + 2'd2);
        PAT_CUSTOM: pix = custom;
        PAT_CHECK:
          pix = dark_sq ? prim(3'b000) : (chk_custom_i ? custom : prim(3'b111));
        PAT_COMB: begin
          if (dark_sq) pix = prim(3'b000);
          else begin
            unique case (comb_idx)
              2'd0: pix = prim(3'b110);
              2'd1: pix = prim(3'b011);
              2'd2: pix = prim(3'b001);
              default: pix = prim(3'b100);
            endcase
          end
        end
        default: pix = prim(3'b000);
      endcase
    end

    pix_x = inv_i ? ~pix : pix;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      de_o  <= 1'b0;
      rgb_o <= '0;
    end else begin
      de_o  <= de_i;
      rgb_o <= de_i ? (pix_x & mask) : 24'h000000;
    end
  end

  a_r2_de_follow: assert property (@(posedge clk) disable iff (rst)
    de_i |=> de_o);

  a_r2_blank_zero: assert property (@(posedge clk) disable iff (rst)
    !de_i |=> (!de_o && rgb_o == 24'h000000));

  a_r6_low_bits: assert property (@(posedge clk) disable iff (rst)
    mode18_i |=> (rgb_o[17:16] == 2'b00 && rgb_o[9:8] == 2'b00 && rgb_o[1:0] == 2'b00));

endmodule

// File: tb/tb_tpg_pixel_gen.sv
module tb_tpg_pixel_gen;
  localparam int PW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          de_i = 1'b0;
  logic [PW-1:0] col_i = '0, row_i = '0, act_w = '0, act_h = '0;
  logic [3:0]    pat_i = '0;
  logic          inv_i = 0, mode18_i = 0, chk_scale_i = 0, chk_custom_i = 0, bars_i = 0;
  logic [7:0]    cust_r_i = 8'h5A, cust_g_i = 8'hC3, cust_b_i = 8'h17;
  logic          de_o;
  logic [23:0]   rgb_o;

  int errors = 0;
  int checks = 0;

  bit        pend = 0;
  bit        pend_de;
  bit [23:0] pend_exp;
  string     pend_tag;

  always #5 clk = ~clk;

  tpg_pixel_gen #(.PW(PW)) dut (
    .clk(clk), .rst(rst), .de_i(de_i), .col_i(col_i), .row_i(row_i),
    .act_w(act_w), .act_h(act_h), .pat_i(pat_i), .inv_i(inv_i),
    .mode18_i(mode18_i), .chk_scale_i(chk_scale_i), .chk_custom_i(chk_custom_i),
    .bars_i(bars_i), .cust_r_i(cust_r_i), .cust_g_i(cust_g_i), .cust_b_i(cust_b_i),
    .de_o(de_o), .rgb_o(rgb_o)
  );

  function automatic bit [23:0] full(input bit r, input bit g, input bit b);
    return {{8{r}}, {8{g}}, {8{b}}};
  endfunction

  function automatic bit [23:0] model(input int c, input int r);
    int span, lvl, byt, sq, band, tsel;
    bit [23:0] v;
    span = mode18_i ? 64 : 256;
    sq   = chk_scale_i ? ((c / 8 + r / 8) % 2) : ((c + r) % 2);
    if (bars_i) begin
      band = c * 8 / int'(act_w);
      case (band)
        0: v = full(1,1,1); 1: v = full(1,1,0); 2: v = full(0,1,1); 3: v = full(0,1,0);
        4: v = full(1,0,1); 5: v = full(1,0,0); 6: v = full(0,0,1); default: v = full(0,0,0);
      endcase
    end else begin
      case (int'(pat_i))
        1: v = 24'hFFFFFF;
        2: v = 24'h000000;
        3: v = 24'hFF0000;
        4: v = 24'h00FF00;
        5: v = 24'h0000FF;
        14: v = {cust_r_i, cust_g_i, cust_b_i};
        0: v = (sq != 0) ? 24'h0 : (chk_custom_i ? {cust_r_i, cust_g_i, cust_b_i} : 24'hFFFFFF);
        15: begin
          if (sq != 0) v = 24'h0;
          else case ((chk_scale_i ? r / 8 : r) % 4)
            0: v = 24'hFFFF00; 1: v = 24'h00FFFF; 2: v = 24'h0000FF; default: v = 24'hFF0000;
          endcase
        end
        default: begin
          if (pat_i <= 9) begin
            lvl = c * span / int'(act_w);
            tsel = int'(pat_i) - 6;
          end else begin
            lvl = r * span / int'(act_h);
            tsel = int'(pat_i) - 10;
          end
          byt = mode18_i ? lvl * 4 : lvl;
          case (tsel)
            0: v = {byt[7:0], byt[7:0], byt[7:0]};
            1: v = {byt[7:0], 16'h0};
            2: v = {8'h0, byt[7:0], 8'h0};
            default: v = {16'h0, byt[7:0]};
          endcase
        end
      endcase
    end
    if (inv_i) v = ~v;
    if (mode18_i) v = v & 24'hFCFCFC;
    return v;
  endfunction

  function automatic string tag_of();
    string t;
    if (bars_i) t = "R11";
    else if (pat_i == 0) t = chk_custom_i ? "R9" : "R8";
    else if (pat_i == 15) t = "R10";
    else if (pat_i >= 6 && pat_i <= 9) t = "R4";
    else if (pat_i >= 10 && pat_i <= 13) t = "R5";
    else t = "R3";
    if (inv_i) t = {t, "+R7"};
    if (mode18_i) t = {t, "+R6"};
    return t;
  endfunction

  task automatic compare();
    if (pend) begin
      checks++;
      if (de_o !== pend_de || rgb_o !== pend_exp) begin
        errors++;
        $display("FAIL %s: got de=%0b rgb=%06h expected de=%0b rgb=%06h",
                 pend_tag, de_o, rgb_o, pend_de, pend_exp);
      end
    end
  endtask

  // one clock: judge the previous cycle, then apply the next inputs
  task automatic step(input bit de, input int c, input int r);
    @(negedge clk);
    compare();
    de_i  = de;
    col_i = PW'(c);
    row_i = PW'(r);
    pend     = 1;
    pend_de  = de;
    pend_exp = de ? model(c, r) : 24'h0;
    pend_tag = de ? tag_of() : "R2";
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  task automatic frame(input int code);
    pat_i = code[3:0];
    for (int r = 0; r < int'(act_h); r++) begin
      for (int c = 0; c < int'(act_w); c++) step(1, c, r);
      idle(2);
    end
  endtask

  task automatic config_set(input int w, input int h, input bit inv, input bit m18,
                            input bit scl, input bit cus, input bit bars);
    @(negedge clk);
    compare();
    pend = 0;
    act_w = PW'(w); act_h = PW'(h);
    inv_i = inv; mode18_i = m18; chk_scale_i = scl; chk_custom_i = cus; bars_i = bars;
    de_i = 0;
    idle(20);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got running expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    act_w = PW'(20); act_h = PW'(6);
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (de_o !== 1'b0 || rgb_o !== 24'h0) begin
      errors++;
      $display("FAIL R1: got de=%0b rgb=%06h expected de=0 rgb=000000", de_o, rgb_o);
    end
    rst = 0;
    @(negedge clk);
    checks++;
    if (de_o !== 1'b0 || rgb_o !== 24'h0) begin
      errors++;
      $display("FAIL R1: got de=%0b rgb=%06h expected de=0 rgb=000000", de_o, rgb_o);
    end

    // plain 24-bit: R3 R4 R5 R8 R10, narrow frame so ramp steps exceed one level
    config_set(20, 6, 0, 0, 0, 0, 0);
    for (int k = 0; k < 16; k++) frame(k);
    // wide frame: ramp levels repeat across columns
    config_set(300, 5, 0, 0, 0, 0, 0);
    frame(6); frame(10); frame(7);
    // inversion R7
    config_set(300, 5, 1, 0, 0, 0, 0);
    for (int k = 0; k < 16; k++) frame(k);
    // custom checkerboard R9 and scaled squares
    config_set(40, 20, 0, 0, 1, 1, 0);
    frame(0); frame(15); frame(14);
    // 18-bit with inversion in the same cycle: R6 with R7
    config_set(40, 20, 1, 1, 1, 1, 0);
    for (int k = 0; k < 16; k++) frame(k);
    config_set(70, 3, 0, 1, 0, 0, 0);
    frame(8); frame(13);
    // colour bar override R11 against several codes
    config_set(37, 3, 0, 0, 0, 0, 1);
    frame(0); frame(6); frame(15); frame(14);
    config_set(8, 2, 1, 1, 0, 0, 1);
    frame(3);
    idle(3);
    @(negedge clk);
    compare();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule